// File: doc/BRIEF.md
# Framed Four-Bit Pattern Checker

This block takes a serial stream one bit per accepted beat and cuts it into consecutive groups of four bits that never overlap. The first accepted bit after reset opens the first group. When the fourth bit of a group arrives, the block decides at once whether the group equals one of two fixed patterns and raises its match output in that same cycle. The match is a Mealy output: it depends on the current input as well as the stored state. After the fourth bit the block always returns to the start of a new group, whether or not the group matched.

The two patterns, written with the first-received bit on the left, are `0101` and `1001`. A group that stops agreeing with both patterns partway through is still counted through to its fourth bit. Only after that does the next group begin, so the framing never slips.

The input follows a valid/ready handshake. A beat is accepted when `in_valid` and `in_ready` are both high. The block never applies back-pressure, so `in_ready` stays high whenever reset is not asserted. Cycles with `in_valid` low carry no bit: the frame position holds and the match output stays low.

Top module: `frame4_pattern_checker`

## Requirements
- R1: While `rst` is high, `match_o` is 0. The first beat accepted after `rst` falls is bit position one of a new group.
- R2: On the fourth bit of a group whose bits, in arrival order, are 0,1,0,1, `match_o` is 1 in the same cycle as that fourth beat.
- R3: On the fourth bit of a group whose bits, in arrival order, are 1,0,0,1, `match_o` is 1 in the same cycle as that fourth beat.
- R4: `match_o` is 0 on the first, second and third bit positions of every group.
- R5: For any group that differs from both patterns, `match_o` is 0 on all four of its beats.
- R6: Groups do not overlap. A pattern that spans two groups is not reported, and a group that has already failed still occupies four beats.
- R7: After every fourth accepted beat the next accepted beat starts a new group, whatever the outcome of the previous group.
- R8: A cycle with `in_valid` low is ignored. `in_bit` has no effect, the frame position does not advance, and `match_o` is 0.
- R9: `in_ready` is 1 in every cycle outside reset (no back-pressure).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat qualifier |
| in_ready | output | 1 | Always high; the block accepts every beat |
| in_bit | input | 1 | Serial data bit |
| match_o | output | 1 | Mealy match flag, high on the fourth bit of a matching group |

## Verification
The assertions assume that `in_bit` and `in_valid` are stable around each rising edge. They also assume that reset is held for at least one edge before any beat counts. The bench drives every input on the falling edge and samples outputs mid-low-phase. It asserts reset at the start and again in the middle of a group, so that both the power-on alignment and the mid-group realignment are covered. Valid gaps are inserted inside groups, so that hold behaviour is exercised while a partial group is in flight.

// File: rtl/frame4_pkg.sv
package frame4_pkg;
  localparam int unsigned GROUP_BITS = 4;
  localparam int unsigned NUM_PATTERNS = 2;
  // Patterns stored with the first-received bit in the most significant position.
  localparam logic [GROUP_BITS-1:0] PATTERN_A = 4'b0101;
  localparam logic [GROUP_BITS-1:0] PATTERN_B = 4'b1001;
  localparam logic [NUM_PATTERNS*GROUP_BITS-1:0] PATTERN_SET = {PATTERN_B, PATTERN_A};
endpackage

// File: rtl/frame4_pos_ctr.sv
module frame4_pos_ctr #(
  parameter int unsigned FRAME_LEN = 4,
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  output logic [POS_W-1:0] pos_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (beat) begin
      if (pos_q == LAST_POS) pos_q <= '0;
      else                   pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o   = pos_q;
  assign first_o = (pos_q == '0);
  assign last_o  = (pos_q == LAST_POS);
endmodule

// File: rtl/frame4_pat_lane.sv
module frame4_pat_lane #(
  parameter int unsigned FRAME_LEN = 4,
  parameter logic [FRAME_LEN-1:0] PATTERN = '0,
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [POS_W-1:0] pos,
  input  logic             first,
  input  logic             last,
  input  logic             bit_in,
  output logic             hit_o
);
  logic alive_q;
  logic exp_bit;
  logic still_ok;

  // Expected bit for the current position: first-received bit sits in the MSB.
  always_comb begin
    exp_bit = PATTERN[FRAME_LEN - 1 - int'(pos)];
  end

  assign still_ok = (first | alive_q) & (bit_in == exp_bit);

  always_ff @(posedge clk) begin
    if (rst)       alive_q <= 1'b0;
    else if (beat) alive_q <= still_ok & ~last;
  end

  assign hit_o = still_ok & last;
endmodule

// File: rtl/frame4_pattern_checker.sv
module frame4_pattern_checker
  import frame4_pkg::*;
#(
  parameter int unsigned FRAME_LEN = GROUP_BITS,
  parameter int unsigned N_PAT = NUM_PATTERNS,
  parameter logic [N_PAT*FRAME_LEN-1:0] PATTERNS = PATTERN_SET,
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic match_o
);
  logic             beat;
  logic [POS_W-1:0] frame_pos;
  logic             at_first;
  logic             at_last;
  logic [N_PAT-1:0] lane_hit;

  assign in_ready = 1'b1;
  assign beat     = in_valid & in_ready & ~rst;

  frame4_pos_ctr #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk    (clk),
    .rst    (rst),
    .beat   (beat),
    .pos_o  (frame_pos),
    .first_o(at_first),
    .last_o (at_last)
  );

  for (genvar k = 0; k < N_PAT; k++) begin : g_lane
    frame4_pat_lane #(
      .FRAME_LEN(FRAME_LEN),
      .PATTERN  (PATTERNS[k*FRAME_LEN +: FRAME_LEN])
    ) u_lane (
      .clk   (clk),
      .rst   (rst),
      .beat  (beat),
      .pos   (frame_pos),
      .first (at_first),
      .last  (at_last),
      .bit_in(in_bit),
      .hit_o (lane_hit[k])
    );
  end

  assign match_o = beat & (|lane_hit);
endmodule

// File: rtl/frame4_checker.sv
module frame4_checker #(
  parameter int unsigned FRAME_LEN = 4,
  localparam int unsigned POS_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_bit,
  input logic             match_o,
  input logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  // Independent count of accepted beats within the group.
  logic [POS_W-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (in_valid && in_ready) seen_q <= (seen_q == LAST_POS) ? '0 : seen_q + 1'b1;
  end

  AST_POS_TRACK: assert property (@(posedge clk) disable iff (rst) pos == seen_q); // R1
  AST_MATCH_LAST_ONLY: assert property (@(posedge clk) disable iff (rst) match_o |-> (seen_q == LAST_POS)); // R4
  AST_MATCH_ENDS_ONE: assert property (@(posedge clk) disable iff (rst) match_o |-> in_bit); // R2
  AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) match_o |-> in_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(pos)); // R8
  AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (rst) (in_valid && pos == LAST_POS) |=> pos == '0); // R7
  AST_READY_UP: assert property (@(posedge clk) disable iff (rst) in_ready); // R9
endmodule

bind frame4_pattern_checker frame4_checker #(.FRAME_LEN(FRAME_LEN)) u_frame4_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_bit  (in_bit),
  .match_o (match_o),
  .pos     (frame_pos)
);

// File: tb/frame4_pattern_checker_bench.sv
`timescale 1ns/1ps
module frame4_pattern_checker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic match_o;

  int n_checks = 0;
  int n_fails = 0;
  int m_pos = 0;
  int m_grp = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame4_pattern_checker u_frame4_pattern_checker (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_bit  (in_bit),
    .match_o (match_o)
  );

  function automatic logic model_z(logic r, logic v, logic b);
    int full;
    full = (m_grp << 1) | int'(b);
    return !r && v && (m_pos == 3) && (full == 5 || full == 9);
  endfunction

  task automatic step(input logic r, input logic v, input logic b, input string tag);
    logic exp_z;
    @(negedge clk);
    rst = r; in_valid = v; in_bit = b;
    #5;
    exp_z = model_z(r, v, b);
    n_checks++;
    if (match_o !== exp_z) begin
      n_fails++;
      $display("FAIL %s: match_o=%b expected %b (pos %0d)", tag, match_o, exp_z, m_pos);
    end
    if (!r) begin
      n_checks++;
      if (in_ready !== 1'b1) begin
        n_fails++;
        $display("FAIL R9: in_ready=%b expected 1", in_ready);
      end
    end
    @(posedge clk);
    if (r) begin
      m_pos = 0; m_grp = 0;
    end else if (v) begin
      if (m_pos == 3) begin m_pos = 0; m_grp = 0; end
      else begin m_grp = (m_grp << 1) | int'(b); m_pos++; end
    end
  endtask

  task automatic send_group(input logic [3:0] g, input string tag);
    for (int i = 3; i >= 0; i--) step(1'b0, 1'b1, g[i], tag);
  endtask

  initial begin
    step(1'b1, 1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, 1'b0, "R1");
    send_group(4'b0101, "R2");
    send_group(4'b1001, "R3");
    send_group(4'b1101, "R5");
    send_group(4'b0000, "R5");
    send_group(4'b1111, "R4");
    // Pattern 0101 straddling a group boundary: 1010 | 1000
    send_group(4'b1010, "R6");
    send_group(4'b1000, "R6");
    // Early-failing group still takes four beats, then 1001 aligns
    send_group(4'b1110, "R7");
    send_group(4'b1001, "R7");
    // Valid gaps inside a group, with toggling bits while idle
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b1, "R8");
    // Reset mid-group then realign
    step(1'b0, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, "R1");
    send_group(4'b0101, "R1");
    // Every group value
    for (int g = 0; g < 16; g++) begin
      send_group(4'(g), (g == 5) ? "R2" : (g == 9) ? "R3" : "R5");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule